// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight hardware request lines into one interrupt signal for a processor. It detects a rising edge on each line and keeps it as a pending request unless that line is masked. A fixed-priority resolver chooses a winner among the pending requests and raises `int_out`. Any line already in service blocks requests of equal or lower priority. The processor answers with two one-cycle `ack` pulses. The first pulse moves the winner from pending to in-service. During the second pulse the block drives a vector byte, which is a programmable base with the line number in its three low bits.

Software uses a small write port. Through it the processor sets the mask, sets the vector base and issues end-of-interrupt commands. Each command either clears the highest-priority in-service line or clears a line it names.

Two instances can be chained. The secondary instance's `int_out` feeds line 2 of the primary. When the primary picks that line with cascade enabled, it leaves the bus undriven and raises `casc_sel_out`. That signal tells the secondary to take part in both acknowledge pulses and to supply its own vector.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A rising edge on a line whose mask bit is 1 is not recorded as pending. Clearing the mask later does not raise `int_out` for that edge.
- R2: A rising edge on an unmasked line stays pending until it is acknowledged. A line held high produces only one request.
- R3: `int_out` is 1 whenever an eligible pending request exists and no acknowledge sequence is half done. Line 0 has the highest priority and line 7 the lowest.
- R4: A request is eligible only if its line number is lower than every line currently in service. A higher-priority request therefore nests above one in service, and a lower one waits.
- R5: On the first `ack` pulse, the winning line's in-service bit is set and its pending bit is cleared. `int_out` then falls until the second pulse.
- R6: During the second `ack` pulse, `vec_oe` is 1 and `vec_out` = {base[7:3], line[2:0]}. `vec_oe` is 0 at every other time.
- R7: Writing `wr_sel`=2 issues an end-of-interrupt. With `wr_data[3]`=0 it clears the highest-priority in-service bit. With `wr_data[3]`=1 it clears the bit named by `wr_data[2:0]`.
- R8: Writing `wr_sel`=0 loads the mask from `wr_data`, where bit n masks line n. Writing `wr_sel`=1 loads the vector base from `wr_data[7:3]`.
- R9: In the primary with `casc_en`=1, if line 2 wins then `casc_sel_out` is 1 from the first pulse through the second. The primary leaves `vec_oe` at 0, and the secondary drives its own vector.
- R10: A secondary instance (`is_secondary`=1) ignores `ack` pulses while `casc_sel_in` is 0. Its pending request survives an acknowledge that the primary grants to another line.
- R11: After reset nothing is pending or in service, the mask is 0 and the base is 0. `int_out`, `vec_oe` and `casc_sel_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, rising-edge sensitive |
| ack | input | 1 | Acknowledge pulse from the processor |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 mask, 1 vector base, 2 end-of-interrupt |
| wr_data | input | 8 | Write data |
| is_secondary | input | 1 | Instance is the secondary in a chain |
| casc_en | input | 1 | Line 2 carries a secondary (primary only) |
| casc_sel_in | input | 1 | Primary has granted the secondary |
| casc_sel_out | output | 1 | Grant to the secondary |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector byte |
| vec_oe | output | 1 | Vector byte is valid on the bus |

## Verification
The resolver is exercised with several request patterns. A single request confirms the basic vector value. Two requests raised together show that fixed priority picks the lower line number. A higher request arriving while a lower one is in service shows nesting. A lower request arriving in the same situation must wait, which separates in-service blocking from plain priority. Masked edges and lines held high show whether the edge detector and mask act before latching. Chained runs check that the secondary is consulted for line 2 and that its pending request survives when the primary grants a different line.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int          CASC_LINE = 2,
  parameter logic [7:0]  MASK_RST  = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  input  logic       ack,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       is_secondary,
  input  logic       casc_en,
  input  logic       casc_sel_in,
  output logic       casc_sel_out,
  output logic       int_out,
  output logic [7:0] vec_out,
  output logic       vec_oe
);
  localparam int NL = 8;
  localparam int IW = 3;

  logic [NL-1:0] irq_q, irr, imr, isr;
  logic [7:IW]   base;
  logic          phase;
  logic [IW-1:0] sel_q;

  logic [NL-1:0] elig, rise, take, eoi_clr;
  logic [IW:0]   isr_top;
  logic          win_ok;
  logic [IW-1:0] win_idx;

  assign rise = irq_in & ~irq_q;
  assign elig = irr & ~imr;

  always_comb begin
    isr_top = (IW+1)'(NL);
    for (int i = NL-1; i >= 0; i--)
      if (isr[i]) isr_top = (IW+1)'(i);
    win_ok  = 1'b0;
    win_idx = '0;
    for (int i = NL-1; i >= 0; i--)
      if (elig[i] && ((IW+1)'(i) < isr_top)) begin
        win_ok  = 1'b1;
        win_idx = IW'(i);
      end
  end

  logic engaged, ack_first, ack_second, eoi_wr, sel_casc;
  assign engaged    = ~is_secondary | casc_sel_in;
  assign ack_first  = ack & engaged & ~phase;
  assign ack_second = ack & engaged & phase;
  assign eoi_wr     = wr_en & (wr_sel == 2'd2);
  assign sel_casc   = casc_en & (sel_q == IW'(CASC_LINE));

  assign take    = (ack_first && win_ok) ? (NL'(1) << win_idx) : '0;
  assign eoi_clr = !eoi_wr ? '0 :
                   wr_data[3] ? (NL'(1) << wr_data[IW-1:0]) :
                   (isr_top < (IW+1)'(NL)) ? (NL'(1) << isr_top[IW-1:0]) : '0;

  assign int_out      = win_ok & ~phase;
  assign casc_sel_out = casc_en & ((phase & (sel_q == IW'(CASC_LINE))) |
                                   (~phase & win_ok & (win_idx == IW'(CASC_LINE))));
  assign vec_oe       = ack_second & ~sel_casc;
  assign vec_out      = vec_oe ? {base, sel_q} : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= '0;
      irr   <= '0;
      imr   <= MASK_RST;
      isr   <= '0;
      base  <= '0;
      phase <= 1'b0;
      sel_q <= '0;
    end else begin
      irq_q <= irq_in;
      irr   <= (irr & ~take) | (rise & ~imr);
      isr   <= (isr & ~eoi_clr) | take;
      if (wr_en && wr_sel == 2'd0) imr  <= wr_data;
      if (wr_en && wr_sel == 2'd1) base <= wr_data[7:IW];
      if (ack_first) begin
        phase <= 1'b1;
        sel_q <= win_ok ? win_idx : IW'(NL-1);
      end else if (ack_second) begin
        phase <= 1'b0;
      end
    end
  end

  AST_MASKED_NOT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr & ~$past(irr) & $past(imr)) == '0)); // R1

  AST_INT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr & ~imr) != '0); // R3

  AST_FIRST_ACK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_first && int_out && !eoi_wr) |=> ($countones(isr) == $countones($past(isr)) + 1)); // R5

  AST_VEC_ONLY_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (ack && phase)); // R6

  AST_EOI_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !wr_data[3] && isr != '0 && !ack_first) |=>
      ($countones(isr) == $countones($past(isr)) - 1)); // R7

  AST_SECONDARY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_secondary && !casc_sel_in && !eoi_wr) |=> $stable(isr)); // R10
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [7:0] p_irq = '0, s_irq = '0;
  logic       ack = 1'b0, casc_mode = 1'b0;
  logic       p_wr = 1'b0, s_wr = 1'b0;
  logic [1:0] wsel = '0;
  logic [7:0] wdat = '0;

  logic       p_int, s_int, p_csel, s_csel, p_oe, s_oe;
  logic [7:0] p_vec, s_vec;
  logic [7:0] p_lines;
  assign p_lines = {p_irq[7:3], casc_mode ? s_int : p_irq[2], p_irq[1:0]};

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(p_lines), .ack(ack),
    .wr_en(p_wr), .wr_sel(wsel), .wr_data(wdat),
    .is_secondary(1'b0), .casc_en(casc_mode), .casc_sel_in(1'b0),
    .casc_sel_out(p_csel), .int_out(p_int), .vec_out(p_vec), .vec_oe(p_oe));

  prio_irq_ctrl u_sec (
    .clk(clk), .rst_n(rst_n), .irq_in(s_irq), .ack(ack),
    .wr_en(s_wr), .wr_sel(wsel), .wr_data(wdat),
    .is_secondary(1'b1), .casc_en(1'b0), .casc_sel_in(p_csel),
    .casc_sel_out(s_csel), .int_out(s_int), .vec_out(s_vec), .vec_oe(s_oe));

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input bit to_sec, input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wsel = s; wdat = d;
    if (to_sec) s_wr = 1'b1; else p_wr = 1'b1;
    @(negedge clk);
    p_wr = 1'b0; s_wr = 1'b0;
  endtask

  logic [7:0] bus;
  logic       p_oe_seen, s_oe_seen;
  task automatic pulse_ack();
    @(negedge clk);
    ack = 1'b1;
    #1;
    bus = p_oe ? p_vec : (s_oe ? s_vec : 8'h00);
    p_oe_seen = p_oe; s_oe_seen = s_oe;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic t_reset();
    idle(1);
    chk("R11 int_out", p_int, 0);
    chk("R11 vec_oe", p_oe, 0);
    chk("R11 casc_sel_out", p_csel, 0);
  endtask

  task automatic t_single();
    wr(0, 2'd1, 8'h40);
    @(negedge clk); p_irq[5] = 1'b1;
    idle(1);
    chk("R2 int after edge", p_int, 1);
    idle(3);
    chk("R2 held pending", p_int, 1);
    pulse_ack();
    chk("R5 int drops after first ack", p_int, 0);
    chk("R6 no vector on first ack", p_oe_seen, 0);
    pulse_ack();
    chk("R6 vector value", bus, 8'h45);
    chk("R6 oe on second ack", p_oe_seen, 1);
    idle(2);
    chk("R2 level held no retrigger", p_int, 0);
    wr(0, 2'd2, 8'h00);
    @(negedge clk); p_irq[5] = 1'b0;
    idle(2);
  endtask

  task automatic t_priority();
    @(negedge clk); p_irq[6] = 1'b1; p_irq[3] = 1'b1;
    idle(1);
    pulse_ack(); pulse_ack();
    chk("R3 lower index wins", bus, 8'h43);
    idle(1);
    chk("R4 lower waits behind in-service", p_int, 0);
    @(negedge clk); p_irq[1] = 1'b1;
    idle(1);
    chk("R4 higher nests", p_int, 1);
    pulse_ack(); pulse_ack();
    chk("R4 nested vector", bus, 8'h41);
    wr(0, 2'd2, 8'h00);
    idle(1);
    chk("R7 nonspecific clears top only", p_int, 0);
    wr(0, 2'd2, 8'h00);
    idle(1);
    chk("R7 second eoi frees line 6", p_int, 1);
    pulse_ack(); pulse_ack();
    chk("R3 pending line 6 vector", bus, 8'h46);
    wr(0, 2'd2, 8'h0E);
    @(negedge clk); p_irq[7] = 1'b1;
    idle(1);
    chk("R7 specific eoi clears line 6", p_int, 1);
    pulse_ack(); pulse_ack();
    chk("R7 line 7 vector", bus, 8'h47);
    wr(0, 2'd2, 8'h0F);
    @(negedge clk); p_irq = '0;
    idle(2);
    chk("R7 all cleared idle", p_int, 0);
  endtask

  task automatic t_mask();
    wr(0, 2'd0, 8'h10);
    @(negedge clk); p_irq[4] = 1'b1;
    idle(3);
    chk("R1 masked edge not forwarded", p_int, 0);
    wr(0, 2'd0, 8'h00);
    idle(2);
    chk("R1 unmask does not revive edge", p_int, 0);
    @(negedge clk); p_irq[4] = 1'b0;
    idle(1);
    @(negedge clk); p_irq[4] = 1'b1;
    idle(1);
    chk("R8 mask cleared new edge seen", p_int, 1);
    pulse_ack(); pulse_ack();
    chk("R8 base kept", bus, 8'h44);
    wr(0, 2'd2, 8'h00);
    @(negedge clk); p_irq = '0;
    idle(2);
  endtask

  task automatic t_cascade();
    @(negedge clk); casc_mode = 1'b1;
    wr(1, 2'd1, 8'h80);
    idle(2);
    @(negedge clk); s_irq[4] = 1'b1;
    idle(3);
    chk("R9 secondary reaches primary", p_int, 1);
    pulse_ack();
    chk("R9 casc_sel_out after first ack", p_csel, 1);
    pulse_ack();
    chk("R9 primary does not drive", p_oe_seen, 0);
    chk("R9 secondary vector", bus, 8'h84);
    idle(1);
    chk("R9 casc_sel_out released", p_csel, 0);
    wr(1, 2'd2, 8'h00);
    wr(0, 2'd2, 8'h00);
    @(negedge clk); s_irq = '0;
    idle(3);
    @(negedge clk); s_irq[5] = 1'b1; p_irq[0] = 1'b1;
    idle(3);
    pulse_ack(); pulse_ack();
    chk("R10 primary line 0 wins", bus, 8'h40);
    chk("R10 secondary silent", s_oe_seen, 0);
    wr(0, 2'd2, 8'h00);
    idle(1);
    chk("R10 cascade request still pending", p_int, 1);
    pulse_ack(); pulse_ack();
    chk("R10 secondary kept its request", bus, 8'h85);
    wr(1, 2'd2, 8'h00);
    wr(0, 2'd2, 8'h00);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_single();
    t_priority();
    t_mask();
    t_cascade();
    idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule